// File: doc/BRIEF.md
# Programmable Periodic-Rate and Square-Wave Generator

This block divides a 32768 Hz reference to produce a square-wave pin and a periodic event. The reference arrives as a level already synchronised to the system clock. A 4-bit rate code picks one tap of a binary divider. Codes 3 to 15 give 8192 Hz down to 2 Hz, halving at each step. Codes 1 and 2 repeat the rates of codes 8 and 9, and code 0 stops the divided output.

A fast-output override puts the raw reference on the pin whatever the rate code is, and stops periodic events while it is set. Each rising edge of the divided signal sets a periodic flag in an 8-bit status word. Two other event inputs (alarm and update) set flags beside it. Each flag is gated by its own enable to form a combined request, which drives an active-low interrupt pin. A read strobe on the status word clears every flag.

Top module: `ptick_gen`

## Requirements
- R1: While reset is held and just after it is released, `sqw_o` is 0, `stat_o` is 0x00 and `irq_no` is 1.
- R2: For rate codes 3 to 15 with `sqw_en_i` set, `sqw_o` has a period of 2^(code-1) reference periods and is high for exactly half of it.
- R3: Rate code 1 gives the same period as code 8 (128 reference periods), and code 2 gives the same period as code 9 (256 reference periods).
- R4: Rate code 0 keeps `sqw_o` at 0 and never sets the periodic flag (`stat_o[6]`).
- R5: While `fast_ovr_i` is 1, `sqw_o` equals `ref_lvl_i` delayed by one system clock, for any rate code and either value of `sqw_en_i`.
- R6: While `fast_ovr_i` is 1, the periodic flag `stat_o[6]` is not set.
- R7: With `sqw_en_i` and `fast_ovr_i` both 0, `sqw_o` stays 0.
- R8: Each rising edge of the divided signal sets `stat_o[6]`, which stays set until a status read.
- R9: A one-cycle `stat_rd_i` pulse clears `stat_o[6:4]` and `stat_o[7]` on the next clock, unless a new event arrives in that same cycle.
- R10: `evt_i[1]` sets `stat_o[5]` and `evt_i[0]` sets `stat_o[4]`. `stat_o[7]` is the OR of `stat_o[6]&irq_en_i[2]`, `stat_o[5]&irq_en_i[1]` and `stat_o[4]&irq_en_i[0]`. `stat_o[3:0]` is always 0, and `irq_no` is the inverse of `stat_o[7]`.
- R11: When the rate code changes, the divider restarts from zero, so the first rising edge of `sqw_o` comes half a new period after the change, within one reference period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_lvl_i | input | 1 | 32768 Hz reference level, synchronous to clk_i |
| rate_sel_i | input | 4 | Rate code |
| sqw_en_i | input | 1 | Square-wave output enable |
| fast_ovr_i | input | 1 | Put the raw reference on the pin and stop periodic events |
| irq_en_i | input | 3 | Request enables: [2] periodic, [1] alarm, [0] update |
| evt_i | input | 2 | Event pulses: [1] alarm, [0] update |
| stat_rd_i | input | 1 | Status read strobe; clears the flags |
| sqw_o | output | 1 | Square-wave output |
| stat_o | output | 8 | Status: [7] request, [6] periodic, [5] alarm, [4] update, [3:0] zero |
| irq_no | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is a rate change in the middle of a period. A stale counter bit could then produce a runt edge or a spurious periodic flag. The stimulus runs the fastest rate, switches to a slower code at an arbitrary cycle, and times the first rising edge against half of the new period. The bench also times the aliased codes against their partners. It clears flags right after a periodic event is seen, so that the read and the next event do not collide.

// File: rtl/ptick_pkg.sv
package ptick_pkg;
  // status word bit positions (software decodes these)
  localparam int STAT_REQ = 7;
  localparam int STAT_PER = 6;
  localparam int STAT_ALM = 5;
  localparam int STAT_UPD = 4;

  // map the two low aliased codes onto their slower partners
  function automatic logic [3:0] fold_code(input logic [3:0] c);
    logic [3:0] r;
    r = c;
    if (c == 4'd1 || c == 4'd2) r = c + 4'd7;
    return r;
  endfunction
endpackage

// File: rtl/ptick_ratedec.sv
module ptick_ratedec #(
  parameter int SEL_W = 4,
  localparam int CNT_W = (1 << SEL_W) - 2,
  localparam int IDX_W = $clog2(CNT_W)
) (
  input  logic [SEL_W-1:0] code_i,
  output logic [IDX_W-1:0] tap_o,
  output logic             live_o
);
  import ptick_pkg::*;
  logic [SEL_W-1:0] eff;

  always_comb begin
    eff    = fold_code(code_i);
    live_o = (code_i != '0);
    // code c divides by 2^(c-1): square wave is counter bit c-2
    tap_o  = (eff >= SEL_W'(3)) ? IDX_W'(eff - SEL_W'(2)) : '0;
  end
endmodule

// File: rtl/ptick_div.sv
module ptick_div #(
  parameter int SEL_W = 4,
  localparam int CNT_W = (1 << SEL_W) - 2,
  localparam int IDX_W = $clog2(CNT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_lvl_i,
  input  logic [SEL_W-1:0] code_i,
  input  logic [IDX_W-1:0] tap_i,
  input  logic             live_i,
  output logic             div_o
);
  logic             ref_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] code_q;
  logic             rise, chg;

  always_comb begin
    rise  = ref_lvl_i & ~ref_q;
    chg   = (code_i != code_q);
    cnt_d = cnt_q;
    if (chg)       cnt_d = '0;
    else if (rise) cnt_d = cnt_q + 1'b1;
    // mask the tap during the restart cycle so no stale bit leaks out
    div_o = live_i & ~chg & cnt_q[tap_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      ref_q  <= ref_lvl_i;
      cnt_q  <= cnt_d;
      code_q <= code_i;
    end
  end

  assert_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> (cnt_q == '0));
endmodule

// File: rtl/ptick_flags.sv
module ptick_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       div_i,
  input  logic       ovr_i,
  input  logic [1:0] evt_i,
  input  logic [2:0] en_i,
  input  logic       rd_i,
  output logic [7:0] stat_o
);
  logic       div_q;
  logic [2:0] flg_q, flg_d, set;
  logic       per_set, req;

  always_comb begin
    per_set = div_i & ~div_q & ~ovr_i;
    set     = {per_set, evt_i};
    flg_d   = (flg_q & ~{3{rd_i}}) | set;
    req     = |(flg_q & en_i);
    stat_o  = {req, flg_q, 4'b0000};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= 1'b0;
      flg_q <= '0;
    end else begin
      div_q <= div_i;
      flg_q <= flg_d;
    end
  end

  assert_per_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_set |=> flg_q[2]);
  assert_rd_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && set == 3'b000) |=> (flg_q == 3'b000));
  assert_ovr_noper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_i && !flg_q[2]) |=> !flg_q[2]);
endmodule

// File: rtl/ptick_gen.sv
module ptick_gen #(
  parameter int SEL_W = 4,
  localparam int CNT_W = (1 << SEL_W) - 2,
  localparam int IDX_W = $clog2(CNT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_lvl_i,
  input  logic [SEL_W-1:0] rate_sel_i,
  input  logic             sqw_en_i,
  input  logic             fast_ovr_i,
  input  logic [2:0]       irq_en_i,
  input  logic [1:0]       evt_i,
  input  logic             stat_rd_i,
  output logic             sqw_o,
  output logic [7:0]       stat_o,
  output logic             irq_no
);
  logic [1:0]       rst_sync;
  logic             rst_n;
  logic [IDX_W-1:0] tap;
  logic             live, div;
  logic             sqw_q, sqw_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  ptick_ratedec #(.SEL_W(SEL_W)) u_dec (
    .code_i(rate_sel_i), .tap_o(tap), .live_o(live));

  ptick_div #(.SEL_W(SEL_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_n), .ref_lvl_i(ref_lvl_i),
    .code_i(rate_sel_i), .tap_i(tap), .live_i(live), .div_o(div));

  ptick_flags u_flg (
    .clk_i(clk_i), .rst_ni(rst_n), .div_i(div), .ovr_i(fast_ovr_i),
    .evt_i(evt_i), .en_i(irq_en_i), .rd_i(stat_rd_i), .stat_o(stat_o));

  always_comb begin
    if (fast_ovr_i) sqw_d = ref_lvl_i;
    else            sqw_d = sqw_en_i & div;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sqw_q <= 1'b0;
    else        sqw_q <= sqw_d;
  end

  assign sqw_o  = sqw_q;
  assign irq_no = ~stat_o[ptick_pkg::STAT_REQ];

  assert_ovr_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    fast_ovr_i |=> (sqw_o == $past(ref_lvl_i)));
  assert_sqw_off_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!sqw_en_i && !fast_ovr_i) |=> !sqw_o);
  assert_code0_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rate_sel_i == '0 && !fast_ovr_i) |=> !sqw_o);
endmodule

// File: tb/sim_ptick_gen.sv
module sim_ptick_gen;
  localparam int CLK_P   = 10;
  localparam int REF_PER = 4;
  localparam int LIM     = 40000;

  logic       clk = 1'b0, rst_n = 1'b0, ref_lvl = 1'b0;
  logic [3:0] rate = 4'd0;
  logic       sqw_en = 1'b0, ovr = 1'b0, rd = 1'b0;
  logic [2:0] ien = 3'b000;
  logic [1:0] evt = 2'b00;
  logic       sqw, irq_n;
  logic [7:0] stat;
  int n_chk = 0, n_err = 0;

  ptick_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_lvl_i(ref_lvl), .rate_sel_i(rate),
    .sqw_en_i(sqw_en), .fast_ovr_i(ovr), .irq_en_i(ien), .evt_i(evt),
    .stat_rd_i(rd), .sqw_o(sqw), .stat_o(stat), .irq_no(irq_n));

  always #(CLK_P/2) clk = ~clk;

  initial begin
    forever begin
      repeat (REF_PER/2) @(negedge clk);
      ref_lvl = ~ref_lvl;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_stat();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic meas(output int per, output int hi);
    int g = 0;
    while (sqw !== 1'b0 && g < LIM) begin @(negedge clk); g++; end
    while (sqw !== 1'b1 && g < LIM) begin @(negedge clk); g++; end
    hi = 0;
    while (sqw === 1'b1 && g < LIM) begin @(negedge clk); hi++; g++; end
    per = hi;
    while (sqw === 1'b0 && g < LIM) begin @(negedge clk); per++; g++; end
  endtask

  task automatic t_reset();
    #(CLK_P*3);
    chk(sqw === 1'b0, "R1 sqw", sqw, 0);
    chk(stat === 8'h00, "R1 stat", stat, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(stat === 8'h00 && irq_n === 1'b1 && sqw === 1'b0, "R1 after release", stat, 0);
  endtask

  task automatic t_rate(input logic [3:0] c, input int eff, input string req);
    int per, hi;
    rate = c; sqw_en = 1'b1;
    meas(per, hi);
    chk(per == (REF_PER << (eff-1)), {req, " period"}, per, REF_PER << (eff-1));
    chk(hi == (REF_PER << (eff-2)), {req, " high time"}, hi, REF_PER << (eff-2));
  endtask

  task automatic t_code0();
    bit seen = 0;
    rate = 4'd0; sqw_en = 1'b1;
    read_stat();
    repeat (600) begin @(negedge clk); if (sqw !== 1'b0) seen = 1; end
    chk(!seen, "R4 sqw quiet", seen, 0);
    chk(stat[6] === 1'b0, "R4 no periodic flag", stat[6], 0);
  endtask

  task automatic t_sqw_off();
    bit seen = 0;
    rate = 4'd3; sqw_en = 1'b0;
    repeat (100) begin @(negedge clk); if (sqw !== 1'b0) seen = 1; end
    chk(!seen, "R7 sqw held low", seen, 0);
  endtask

  task automatic t_override();
    int per, hi;
    int bad = 0;
    logic prev;
    rate = 4'd6; sqw_en = 1'b0; ovr = 1'b1;
    @(negedge clk);
    read_stat();
    prev = ref_lvl;
    repeat (300) begin
      @(negedge clk);
      if (sqw !== prev) bad++;
      prev = ref_lvl;
    end
    chk(bad == 0, "R5 follows reference", bad, 0);
    meas(per, hi);
    chk(per == REF_PER, "R5 period", per, REF_PER);
    chk(stat[6] === 1'b0, "R6 no periodic flag in override", stat[6], 0);
    ovr = 1'b0;
  endtask

  task automatic t_periodic();
    int g = 0;
    rate = 4'd6; sqw_en = 1'b1; ien = 3'b000;
    read_stat();
    while (stat[6] !== 1'b1 && g < 1000) begin @(negedge clk); g++; end
    chk(stat[6] === 1'b1, "R8 periodic flag sets", stat[6], 1);
    chk(stat[7] === 1'b0 && irq_n === 1'b1, "R10 masked request", stat[7], 0);
    ien = 3'b100;
    @(negedge clk);
    chk(stat[7] === 1'b1 && irq_n === 1'b0, "R10 enabled request", stat[7], 1);
    repeat (10) @(negedge clk);
    chk(stat[6] === 1'b1, "R8 flag holds", stat[6], 1);
    read_stat();
    chk(stat[7:4] === 4'h0 && irq_n === 1'b1, "R9 read clears", stat, 0);
    ien = 3'b000;
  endtask

  task automatic t_events();
    rate = 4'd0;
    read_stat();
    @(negedge clk) evt = 2'b10;
    @(negedge clk) evt = 2'b00;
    chk(stat === 8'h20, "R10 alarm flag", stat, 8'h20);
    ien = 3'b010;
    @(negedge clk);
    chk(stat === 8'hA0 && irq_n === 1'b0, "R10 alarm request", stat, 8'hA0);
    @(negedge clk) evt = 2'b01;
    @(negedge clk) evt = 2'b00;
    ien = 3'b001;
    @(negedge clk);
    chk(stat === 8'hB0, "R10 update flag and low bits zero", stat, 8'hB0);
    read_stat();
    chk(stat === 8'h00 && irq_n === 1'b1, "R9 read clears all", stat, 0);
    ien = 3'b000;
  endtask

  task automatic t_restart();
    int n = 0;
    rate = 4'd3; sqw_en = 1'b1;
    repeat (37) @(negedge clk);
    rate = 4'd6;
    while (sqw !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
    // half of 32 reference periods = 64 clocks, within one reference period
    chk(n >= 64 - REF_PER && n <= 64 + REF_PER + 2, "R11 first edge after change", n, 64);
  endtask

  initial begin
    #(CLK_P*190000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_rate(4'd3, 3, "R2 code3");
    t_rate(4'd4, 4, "R2 code4");
    t_rate(4'd6, 6, "R2 code6");
    t_rate(4'd12, 12, "R2 code12");
    t_rate(4'd8, 8, "R3 code8");
    t_rate(4'd1, 8, "R3 code1");
    t_rate(4'd2, 9, "R3 code2");
    t_code0();
    t_sqw_off();
    t_override();
    t_periodic();
    t_events();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule